// File: doc/BRIEF.md
# CAN Transceiver Fault Diagnosis and Error Indicator

This block watches the digital side of a high-speed CAN transceiver and detects the faults that can be observed there. These are a transmit input held dominant too long, a receive output stuck recessive while the bus is dominant, a short between the transmit and receive pins, overtemperature, and a bus held dominant too long. The first four are hard faults. They are latched into a local failure flag and they switch the transmitter off. A long dominant bus raises the local failure flag only while it lasts and leaves the transmitter running. The block also counts transmit cycles in which the driver saw a shorted bus line, and it raises a sticky bus failure flag after four such cycles in a row.

An active-low error output shows one internal flag at a time. The mode selects which flag is shown. In normal mode the choice also depends on how many dominant-to-recessive transmit edges have passed since normal mode was entered. In listen-only mode it depends on the mode that listen-only was entered from. The power-mode sequencer that owns the modes supplies the current mode, the previous mode and the wake-up, wake-source and power-on flags.

Top module: `can_fault_diag`

## Requirements
- R1: Mode codes are 0 sleep, 1 standby, 2 go-to-sleep command, 3 listen-only and 4 normal; codes 5 to 7 act like standby. TXD and RXD use 0 for dominant. Internal state leaves reset on the second rising edge after rst_n rises. After reset, local_fail_o, bus_fail_o and tx_disable_o are 0.
- R2: If TXD is sampled dominant on TXD_TO_CYC+1 consecutive edges in mode 3 or 4, tx_disable_o and local_fail_o are 1 after that edge.
- R3: If bus_dom_i=1 and rxd_pin_i=1 are sampled together on RXD_CLAMP_CYC+1 consecutive edges in mode 3 or 4, the hard fault latches.
- R4: If rxd_int_i=1 and rxd_pin_i=0 are sampled together on SHORT_CYC+1 consecutive edges in mode 3 or 4, the hard fault latches.
- R5: If overtemp_i is sampled high at an edge in mode 3 or 4, the hard fault latches on that edge.
- R6: After bus_dom_i has been sampled high on BUS_TO_CYC+1 consecutive edges, local_fail_o is 1 while bus_dom_i stays high in mode 3 or 4, and tx_disable_o is not raised. The indication drops in the same cycle that bus_dom_i falls.
- R7: Hard faults are not recognised in modes 0, 1, 2 or 5 to 7. A latched fault is kept in those modes.
- R8: The latched fault and tx_disable_o clear at an edge that is an entry into mode 4, or at an edge where rxd_int_i=0 and txd_i=1. The clear happens only if no fault condition of R2 to R6 is present at that edge.
- R9: In mode 4, a TXD cycle counts as shorted if bus_short_i was sampled high while TXD was dominant before its rising edge. Four shorted cycles in a row set bus_fail_o, and a cycle that is not shorted restarts the count. Entry into mode 4 clears bus_fail_o.
- R10: The count of dominant-to-recessive TXD edges in mode 4 resets on each entry into mode 4. An edge that falls on the entry edge is not counted. The count saturates at four.
- R11: In mode 4, err_n_o is the inverse of wake_src_i until the fourth counted edge, and the inverse of bus_fail_o from then on.
- R12: In mode 3, err_n_o is the inverse of local_fail_o when prev_mode_i is 4, and the inverse of pwon_flag_i otherwise.
- R13: In every mode other than 3 and 4, err_n_o is the inverse of wake_flag_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit data from the controller, 0 = dominant |
| rxd_int_i | input | 1 | Receiver output before the pin driver, 0 = dominant |
| rxd_pin_i | input | 1 | Level read back from the RXD pin |
| bus_dom_i | input | 1 | Bus comparator reports dominant |
| bus_short_i | input | 1 | Driver reports a shorted bus line |
| overtemp_i | input | 1 | Junction overtemperature level |
| mode_i | input | 3 | Current operating mode |
| prev_mode_i | input | 3 | Mode the current mode was entered from |
| wake_flag_i | input | 1 | Wake-up flag |
| wake_src_i | input | 1 | Local wake-up source flag |
| pwon_flag_i | input | 1 | Power-on flag |
| local_fail_o | output | 1 | Local failure flag |
| bus_fail_o | output | 1 | Bus failure flag |
| tx_disable_o | output | 1 | Transmitter switched off |
| err_n_o | output | 1 | Active-low error indicator |

## Verification
On every cycle, the assertions check the following:
- A persistence detector never fires without the condition having been present on the previous edge.
- Overtemperature in an active mode always latches the fault.
- A latched fault never releases while a condition is still present.
- The edge count stays bounded.
- Entry into normal mode clears the bus failure state.

Only the scenarios of the reference-model bench can show the rest. That covers the exact timeout lengths, the way a clean TXD cycle restarts the shorted-cycle run, the choice of flag on the error output for each mode and each previous mode, and the rule that an edge coinciding with normal-mode entry is not counted.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;

  typedef enum logic [2:0] {
    MD_SLEEP   = 3'd0,
    MD_STANDBY = 3'd1,
    MD_GOSLEEP = 3'd2,
    MD_LISTEN  = 3'd3,
    MD_NORMAL  = 3'd4
  } mode_e;

  // Modes in which local failures are recognised
  function automatic logic mode_active(input logic [2:0] m);
    return (m == MD_NORMAL) || (m == MD_LISTEN);
  endfunction

endpackage

// File: rtl/fdiag_persist.sv
module fdiag_persist #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic hit_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!cond_i)          cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Fires once the condition has held for LIMIT earlier edges as well
  assign hit_o = cond_i && (cnt_q == LIM);

  p_hit_history_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(cond_i));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/fdiag_local.sv
module fdiag_local #(
  parameter int unsigned TXD_TO_CYC    = 60000,
  parameter int unsigned RXD_CLAMP_CYC = 8,
  parameter int unsigned SHORT_CYC     = 8,
  parameter int unsigned BUS_TO_CYC    = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic rxd_int_i,
  input  logic rxd_pin_i,
  input  logic bus_dom_i,
  input  logic overtemp_i,
  input  logic mode_ok_i,
  input  logic enter_norm_i,
  output logic local_fail_o,
  output logic tx_dis_o
);

  localparam int NDET = 4;
  localparam int unsigned LIMS [NDET] = '{TXD_TO_CYC, RXD_CLAMP_CYC, SHORT_CYC, BUS_TO_CYC};

  logic [NDET-1:0] conds;
  logic [NDET-1:0] hits;
  logic            hard_hit, present, set_c, clr_c;
  logic            lat_q, lat_d;

  // 0: TXD dominant time-out, 1: RXD clamped recessive,
  // 2: TXD-to-RXD short, 3: bus held dominant (not latched)
  assign conds[0] = !txd_i;
  assign conds[1] = bus_dom_i && rxd_pin_i;
  assign conds[2] = rxd_int_i && !rxd_pin_i;
  assign conds[3] = bus_dom_i;

  for (genvar g = 0; g < NDET; g++) begin : g_det
    fdiag_persist #(.LIMIT(LIMS[g])) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (conds[g]),
      .hit_o  (hits[g])
    );
  end

  assign hard_hit = hits[0] | hits[1] | hits[2] | overtemp_i;
  assign present  = hard_hit | hits[3];
  assign set_c    = mode_ok_i && hard_hit;
  assign clr_c    = (enter_norm_i || (!rxd_int_i && txd_i)) && !present;

  always_comb begin
    lat_d = lat_q;
    if (set_c)      lat_d = 1'b1;
    else if (clr_c) lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  assign tx_dis_o     = lat_q;
  assign local_fail_o = lat_q | (mode_ok_i & hits[3]);

  p_overtemp_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ok_i && overtemp_i) |=> tx_dis_o);

  p_rise_needs_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> $past(mode_ok_i && hard_hit));

  p_clear_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && present) |=> lat_q);

endmodule

// File: rtl/fdiag_busfail.sv
module fdiag_busfail #(
  parameter int unsigned EDGE_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic bus_short_i,
  input  logic in_norm_i,
  input  logic enter_norm_i,
  output logic bus_fail_o,
  output logic edges_done_o
);

  localparam int unsigned EW = $clog2(EDGE_LIMIT + 1);
  localparam logic [EW-1:0] ELIM = EW'(EDGE_LIMIT);

  logic          txd_q;
  logic          rise;
  logic [EW-1:0] ecnt_q, ecnt_d;
  logic [EW-1:0] run_q, run_d;
  logic          seen_q, seen_d;
  logic          bfail_q, bfail_d;

  assign rise = txd_i && !txd_q;

  always_comb begin
    ecnt_d  = ecnt_q;
    run_d   = run_q;
    seen_d  = seen_q;
    bfail_d = bfail_q;
    if (enter_norm_i) begin
      ecnt_d  = '0;
      run_d   = '0;
      seen_d  = 1'b0;
      bfail_d = 1'b0;
    end else if (in_norm_i) begin
      if (rise) begin
        if (ecnt_q != ELIM) ecnt_d = ecnt_q + 1'b1;
        if (!seen_q)             run_d = '0;
        else if (run_q != ELIM)  run_d = run_q + 1'b1;
        seen_d = 1'b0;
        if (run_d == ELIM) bfail_d = 1'b1;
      end else if (!txd_i && bus_short_i) begin
        seen_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= 1'b1;
      ecnt_q  <= '0;
      run_q   <= '0;
      seen_q  <= 1'b0;
      bfail_q <= 1'b0;
    end else begin
      txd_q   <= txd_i;
      ecnt_q  <= ecnt_d;
      run_q   <= run_d;
      seen_q  <= seen_d;
      bfail_q <= bfail_d;
    end
  end

  assign bus_fail_o   = bfail_q;
  assign edges_done_o = (ecnt_q == ELIM);

  p_edge_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt_q <= ELIM);

  p_entry_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enter_norm_i |=> (!bus_fail_o && ecnt_q == '0));

  p_bfail_in_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bfail_q) |-> $past(in_norm_i));

endmodule

// File: rtl/fdiag_errsel.sv
module fdiag_errsel
  import fdiag_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [2:0] prev_mode_i,
  input  logic       edges_done_i,
  input  logic       bus_fail_i,
  input  logic       local_fail_i,
  input  logic       wake_flag_i,
  input  logic       wake_src_i,
  input  logic       pwon_flag_i,
  output logic       err_n_o
);

  logic shown;

  always_comb begin
    if (mode_i == MD_NORMAL)
      shown = edges_done_i ? bus_fail_i : wake_src_i;
    else if (mode_i == MD_LISTEN)
      shown = (prev_mode_i == MD_NORMAL) ? local_fail_i : pwon_flag_i;
    else
      shown = wake_flag_i;
  end

  assign err_n_o = !shown;

endmodule

// File: rtl/can_fault_diag.sv
module can_fault_diag
  import fdiag_pkg::*;
#(
  parameter int unsigned TXD_TO_CYC    = 60000,
  parameter int unsigned RXD_CLAMP_CYC = 8,
  parameter int unsigned SHORT_CYC     = 8,
  parameter int unsigned BUS_TO_CYC    = 60000,
  parameter int unsigned EDGE_LIMIT    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txd_i,
  input  logic       rxd_int_i,
  input  logic       rxd_pin_i,
  input  logic       bus_dom_i,
  input  logic       bus_short_i,
  input  logic       overtemp_i,
  input  logic [2:0] mode_i,
  input  logic [2:0] prev_mode_i,
  input  logic       wake_flag_i,
  input  logic       wake_src_i,
  input  logic       pwon_flag_i,
  output logic       local_fail_o,
  output logic       bus_fail_o,
  output logic       tx_disable_o,
  output logic       err_n_o
);

  logic [1:0] sync_q;
  logic       rst_sn;
  logic [2:0] mode_q;
  logic       in_norm, enter_norm, mode_ok;
  logic       edges_done;
  logic       local_fail, bus_fail;

  // Reset asserts at once and is released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sn = sync_q[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) mode_q <= MD_SLEEP;
    else         mode_q <= mode_i;
  end

  assign in_norm    = (mode_i == MD_NORMAL);
  assign enter_norm = in_norm && (mode_q != MD_NORMAL);
  assign mode_ok    = mode_active(mode_i);

  fdiag_local #(
    .TXD_TO_CYC    (TXD_TO_CYC),
    .RXD_CLAMP_CYC (RXD_CLAMP_CYC),
    .SHORT_CYC     (SHORT_CYC),
    .BUS_TO_CYC    (BUS_TO_CYC)
  ) u_local (
    .clk          (clk),
    .rst_n        (rst_sn),
    .txd_i        (txd_i),
    .rxd_int_i    (rxd_int_i),
    .rxd_pin_i    (rxd_pin_i),
    .bus_dom_i    (bus_dom_i),
    .overtemp_i   (overtemp_i),
    .mode_ok_i    (mode_ok),
    .enter_norm_i (enter_norm),
    .local_fail_o (local_fail),
    .tx_dis_o     (tx_disable_o)
  );

  fdiag_busfail #(.EDGE_LIMIT(EDGE_LIMIT)) u_bus (
    .clk          (clk),
    .rst_n        (rst_sn),
    .txd_i        (txd_i),
    .bus_short_i  (bus_short_i),
    .in_norm_i    (in_norm),
    .enter_norm_i (enter_norm),
    .bus_fail_o   (bus_fail),
    .edges_done_o (edges_done)
  );

  fdiag_errsel u_err (
    .mode_i       (mode_i),
    .prev_mode_i  (prev_mode_i),
    .edges_done_i (edges_done),
    .bus_fail_i   (bus_fail),
    .local_fail_i (local_fail),
    .wake_flag_i  (wake_flag_i),
    .wake_src_i   (wake_src_i),
    .pwon_flag_i  (pwon_flag_i),
    .err_n_o      (err_n_o)
  );

  assign local_fail_o = local_fail;
  assign bus_fail_o   = bus_fail;

endmodule

// File: tb/can_fault_diag_bench.sv
`timescale 1ns/1ps
module can_fault_diag_bench;

  localparam int P_TXD = 20;
  localparam int P_RXC = 3;
  localparam int P_SH  = 3;
  localparam int P_BUS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, rxd_int = 1'b1, rxd_pin = 1'b1, bus_dom = 1'b0, bus_short = 1'b0, ot = 1'b0;
  logic [2:0] mode = 3'd1, prev = 3'd0;
  logic wake = 1'b0, wsrc = 1'b0, pwon = 1'b0;
  logic local_fail, bus_fail, tx_dis, err_n;

  always #2.5 clk = ~clk;

  can_fault_diag #(
    .TXD_TO_CYC(P_TXD), .RXD_CLAMP_CYC(P_RXC), .SHORT_CYC(P_SH), .BUS_TO_CYC(P_BUS)
  ) u_can_fault_diag (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .rxd_int_i(rxd_int), .rxd_pin_i(rxd_pin),
    .bus_dom_i(bus_dom), .bus_short_i(bus_short), .overtemp_i(ot), .mode_i(mode),
    .prev_mode_i(prev), .wake_flag_i(wake), .wake_src_i(wsrc), .pwon_flag_i(pwon),
    .local_fail_o(local_fail), .bus_fail_o(bus_fail), .tx_disable_o(tx_dis), .err_n_o(err_n)
  );

  // Reference model state
  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  string tag = "R1";
  bit  s1 = 0, s2 = 0;
  int  mq = 0, ct = 0, cr = 0, cs = 0, cb = 0, ec = 0, cc = 0;
  bit  tq = 1, lat = 0, sn = 0, bf = 0;

  function automatic bit hb();
    return bus_dom && cb == P_BUS;
  endfunction

  function automatic bit act_mode();
    return mode == 3 || mode == 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !s2) begin
      mq = 0; ct = 0; cr = 0; cs = 0; cb = 0; ec = 0; cc = 0;
      tq = 1; lat = 0; sn = 0; bf = 0;
    end else begin
      bit h_t, h_r, h_s, h_b, hard, pres, entry, rise;
      h_t = !txd && ct == P_TXD;
      h_r = bus_dom && rxd_pin && cr == P_RXC;
      h_s = rxd_int && !rxd_pin && cs == P_SH;
      h_b = hb();
      hard = h_t || h_r || h_s || ot;
      pres = hard || h_b;
      entry = (mode == 4) && (mq != 4);
      if (act_mode() && hard) lat = 1;
      else if ((entry || (!rxd_int && txd)) && !pres) lat = 0;
      ct = !txd ? ((ct < P_TXD) ? ct + 1 : ct) : 0;
      cr = (bus_dom && rxd_pin) ? ((cr < P_RXC) ? cr + 1 : cr) : 0;
      cs = (rxd_int && !rxd_pin) ? ((cs < P_SH) ? cs + 1 : cs) : 0;
      cb = bus_dom ? ((cb < P_BUS) ? cb + 1 : cb) : 0;
      rise = txd && !tq;
      if (entry) begin
        ec = 0; cc = 0; sn = 0; bf = 0;
      end else if (mode == 4) begin
        if (rise) begin
          if (ec < 4) ec++;
          cc = sn ? ((cc < 4) ? cc + 1 : cc) : 0;
          sn = 0;
          if (cc == 4) bf = 1;
        end else if (!txd && bus_short) sn = 1;
      end
      tq = txd; mq = mode;
    end
    if (!rst_n) begin s1 = 0; s2 = 0; end
    else begin s2 = s1; s1 = 1; end
  end

  task automatic cmp(input string what, input logic act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit e_lf, e_shown;
      e_lf = lat || (act_mode() && hb());
      if (mode == 4)      e_shown = (ec == 4) ? bf : wsrc;
      else if (mode == 3) e_shown = (prev == 4) ? e_lf : pwon;
      else                e_shown = wake;
      cmp("local_fail", local_fail, e_lf);
      cmp("bus_fail",   bus_fail,   bf);
      cmp("tx_disable", tx_dis,     lat);
      cmp("err_n",      err_n,      !e_shown);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    tag = "R1";  tick(3); rst_n = 1; tick(5);
    tag = "R13"; wake = 1; tick(2); mode = 0; tick(2); mode = 2; tick(2); mode = 6; tick(2); wake = 0; tick(2);
    tag = "R11"; mode = 4; prev = 1; tick(2); wsrc = 1; tick(3);
    tag = "R10"; for (int i = 0; i < 6; i++) begin txd = 0; tick(2); txd = 1; tick(2); end
    tag = "R9";
    for (int i = 0; i < 4; i++) begin txd = 0; bus_short = 1; tick(2); bus_short = 0; txd = 1; tick(2); end
    tick(2); mode = 1; tick(2); mode = 4; tick(2);
    for (int i = 0; i < 7; i++) begin txd = 0; bus_short = (i != 3); tick(2); bus_short = 0; txd = 1; tick(2); end
    tag = "R2";  txd = 0; tick(P_TXD + 5); txd = 1; tick(3);
    tag = "R8";  rxd_int = 0; tick(2); rxd_int = 1; tick(2);
    tag = "R3";  bus_dom = 1; rxd_pin = 1; tick(P_RXC + 3); bus_dom = 0; tick(2); rxd_int = 0; tick(1); rxd_int = 1; tick(2);
    tag = "R4";  rxd_pin = 0; tick(P_SH + 3); rxd_pin = 1; tick(2); mode = 1; tick(2); mode = 4; tick(2);
    tag = "R5";  ot = 1; tick(3); rxd_int = 0; tick(3); ot = 0; tick(3); rxd_int = 1; tick(2);
    tag = "R6";  bus_dom = 1; rxd_int = 0; rxd_pin = 0; tick(P_BUS + 4); bus_dom = 0; rxd_int = 1; rxd_pin = 1; tick(3);
    tag = "R7";  mode = 1; ot = 1; tick(4); mode = 3; prev = 1; tick(2); ot = 0; tick(1);
    tag = "R12"; pwon = 1; tick(2); pwon = 0; tick(2); prev = 4; tick(2);
    tag = "R7";  mode = 1; rxd_int = 0; tick(3); rxd_int = 1; mode = 4; tick(3);
    tag = "R10"; mode = 1; txd = 0; tick(2); mode = 4; txd = 1; tick(1);
    for (int i = 0; i < 4; i++) begin txd = 0; tick(2); txd = 1; tick(2); end
    tick(3);
    finish_run();
  end

endmodule